// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host access to a bank of internal registers through a three-word window: a command word, a shared data word and a status word. The host writes the command word to start one access. The command holds an internal register address and a direction flag. A write access copies the data word into the addressed register. A read access copies the addressed register into the data word. Each access runs for a fixed number of cycles, and only one access can be in flight at a time.

The internal bank contains the following registers:
- a set of configuration registers;
- a small address-filter table;
- an interrupt-mask register;
- a 16-bit holding register for management-interface write data. Management reads do not use this register: their results return through the shared data word.

Every finished access belongs to one of seven classes. Each class sets its own sticky status bit. A status bit raises the interrupt line only when the matching mask bit is 1.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the command, data and status windows read 0, `busy`, `irq` and `cmd_err` are 0, and the interrupt-mask register (internal address 0x3A4) reads 0.
- R2: A command-window write with bit 15 clear starts a read. When the read finishes, the data window holds the value of the internal register addressed by bits [9:0]. A read completion takes priority over a host write to the data window in the same cycle.
- R3: A command-window write with bit 15 set starts a write. The current data-window value is copied into the internal register addressed by bits [9:0].
- R4: `busy` goes high on the clock edge that accepts a command and stays high for exactly LATENCY (4) cycles. Status bit 8 mirrors `busy`.
- R5: A command-window write while `busy` is high is ignored: no access is started and the command readback does not change. The cycle after the rejected write, `cmd_err` is high for exactly one cycle.
- R6: The interrupt-mask register at 0x3A4 implements 7 bits in [6:0] and reads 0 in bits [31:7]. Writing 0x7F enables all seven classes.
- R7: The management write-data holding register at 0x3B0 stores bits [15:0] and reads 0 in bits [31:16].
- R8: The configuration registers sit at internal addresses 0x200 to 0x207. The address-filter table sits at 0x380 to 0x383. Each entry is 32 bits, and each entry is independent of the others.
- R9: When an access finishes, the bridge sets one sticky bit in status bits [6:0] for the access class. The classes are: bit 0 configuration read, bit 1 configuration write, bit 2 filter read, bit 3 filter write, bit 4 mask-register access, bit 5 holding-register access, bit 6 unmapped address.
- R10: Writing 1 to a status bit [6:0] clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit [6:0] is set and the matching interrupt-mask bit is 1.
- R12: An access to an unmapped internal address still finishes normally. A read of such an address returns 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Window select: 0 command, 1 data, 2 status, 3 reads zero |
| host_we | input | 1 | Host write strobe for the selected window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the selected window (combinational) |
| busy | output | 1 | An access is in flight |
| irq | output | 1 | Masked completion interrupt |
| cmd_err | output | 1 | One-cycle pulse after a command write that was rejected |

## Verification
The bench runs writes and reads against the following targets:
- two configuration entries with different values, which shows that each entry is decoded on its own;
- a filter-table entry, which separates the filter class from the configuration class;
- the mask and holding registers with all-ones data, which exposes any stored or leaked upper bits;
- an unmapped address, which shows that such an access still finishes with a zero result.

A second command issued in the middle of an access separates acceptance from rejection, and it checks the exact length of `busy`. An interrupt sequence enables only one class, and it shows that other sticky bits stay silent until that class is cleared by a write of 1.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int NCLS   = 7;
    localparam int WE_BIT = 15;
    localparam int HOLD_W = 16;

    localparam logic [ADDR_W-1:0] CFG_BASE  = 10'h200;
    localparam logic [ADDR_W-1:0] AF_BASE   = 10'h380;
    localparam logic [ADDR_W-1:0] IE_ADDR   = 10'h3A4;
    localparam logic [ADDR_W-1:0] HOLD_ADDR = 10'h3B0;

    typedef enum logic [2:0] {
        CL_CFG_RD = 3'd0,
        CL_CFG_WR = 3'd1,
        CL_AF_RD  = 3'd2,
        CL_AF_WR  = 3'd3,
        CL_IE     = 3'd4,
        CL_HOLD   = 3'd5,
        CL_NONE   = 3'd6
    } acc_cls_e;

    typedef enum logic [1:0] {
        WIN_CTRL = 2'd0,
        WIN_DATA = 2'd1,
        WIN_STAT = 2'd2,
        WIN_RSVD = 2'd3
    } win_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
    } icmd_t;

    function automatic acc_cls_e classify(icmd_t c, int cfg_num, int af_num);
        int cfg_off;
        int af_off;
        cfg_off = int'(c.addr) - int'(CFG_BASE);
        af_off  = int'(c.addr) - int'(AF_BASE);
        if (cfg_off >= 0 && cfg_off < cfg_num)
            return c.we ? CL_CFG_WR : CL_CFG_RD;
        else if (af_off >= 0 && af_off < af_num)
            return c.we ? CL_AF_WR : CL_AF_RD;
        else if (c.addr == IE_ADDR)
            return CL_IE;
        else if (c.addr == HOLD_ADDR)
            return CL_HOLD;
        else
            return CL_NONE;
    endfunction
endpackage

// File: rtl/ireg_seq.sv
module ireg_seq
    import ireg_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_req,
    input  icmd_t cmd_in,
    output logic  busy,
    output logic  done,
    output icmd_t cmd_q,
    output logic  rejected
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(LATENCY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cmd_q    <= '0;
            rejected <= 1'b0;
        end else begin
            rejected <= start_req && busy;
            if (!busy) begin
                if (start_req) begin
                    busy  <= 1'b1;
                    cnt   <= '0;
                    cmd_q <= cmd_in;
                end
            end else if (done) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cnt) < LATENCY));
    p_end_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (start_req && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_pkg::*;
#(
    parameter int CFG_NUM = 8,
    parameter int AF_NUM  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              we,
    input  acc_cls_e          cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic [NCLS-1:0]   ie_q
);
    localparam int CI_W = (CFG_NUM > 1) ? $clog2(CFG_NUM) : 1;
    localparam int AI_W = (AF_NUM > 1) ? $clog2(AF_NUM) : 1;

    logic [DATA_W-1:0] cfg_mem [CFG_NUM];
    logic [DATA_W-1:0] af_mem  [AF_NUM];
    logic [HOLD_W-1:0] hold_q;
    logic [CI_W-1:0]   cfg_idx;
    logic [AI_W-1:0]   af_idx;

    assign cfg_idx = CI_W'(addr - CFG_BASE);
    assign af_idx  = AI_W'(addr - AF_BASE);

    for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_mem[g] <= '0;
            else if (done && cls == CL_CFG_WR && cfg_idx == CI_W'(g))
                cfg_mem[g] <= wdata;
        end
    end

    for (genvar g = 0; g < AF_NUM; g++) begin : g_af
        always_ff @(posedge clk) begin
            if (rst)
                af_mem[g] <= '0;
            else if (done && cls == CL_AF_WR && af_idx == AI_W'(g))
                af_mem[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= '0;
            hold_q <= '0;
        end else if (done && we) begin
            if (cls == CL_IE)   ie_q   <= wdata[NCLS-1:0];
            if (cls == CL_HOLD) hold_q <= wdata[HOLD_W-1:0];
        end
    end

    always_comb begin
        case (cls)
            CL_CFG_RD: rd_val = cfg_mem[cfg_idx];
            CL_AF_RD:  rd_val = af_mem[af_idx];
            CL_IE:     rd_val = {{(DATA_W-NCLS){1'b0}}, ie_q};
            CL_HOLD:   rd_val = {{(DATA_W-HOLD_W){1'b0}}, hold_q};
            default:   rd_val = '0;
        endcase
    end

    p_ie_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !(done && we && cls == CL_IE) |=> $stable(ie_q));
    p_hold_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !(done && we && cls == CL_HOLD) |=> $stable(hold_q));
endmodule

// File: rtl/ireg_irq.sv
module ireg_irq
    import ireg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_vld,
    input  acc_cls_e        set_cls,
    input  logic [NCLS-1:0] clr_mask,
    input  logic [NCLS-1:0] en,
    output logic [NCLS-1:0] stat_q,
    output logic            irq
);
    logic [NCLS-1:0] set_vec;

    assign set_vec = set_vld ? (NCLS'(1) << set_cls) : '0;
    assign irq     = |(stat_q & en);

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_mask) | set_vec;
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    p_set_on_done_r9: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int CFG_NUM = 8,
    parameter int AF_NUM  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  host_sel,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic        irq,
    output logic        cmd_err
);
    logic              ctrl_wr;
    icmd_t             cmd_in;
    icmd_t             cmd_q;
    logic              done;
    acc_cls_e          cls;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] data_q;
    logic [NCLS-1:0]   ie_q;
    logic [NCLS-1:0]   stat_q;
    logic [NCLS-1:0]   clr_mask;
    win_e              win;

    assign win     = win_e'(host_sel);
    assign ctrl_wr = host_we && (win == WIN_CTRL);
    assign cmd_in  = '{we: host_wdata[WE_BIT], addr: host_wdata[ADDR_W-1:0]};
    assign cls     = classify(cmd_q, CFG_NUM, AF_NUM);
    assign clr_mask = (host_we && win == WIN_STAT) ? host_wdata[NCLS-1:0] : '0;

    ireg_seq #(.LATENCY(LATENCY)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (ctrl_wr),
        .cmd_in    (cmd_in),
        .busy      (busy),
        .done      (done),
        .cmd_q     (cmd_q),
        .rejected  (cmd_err)
    );

    ireg_bank #(.CFG_NUM(CFG_NUM), .AF_NUM(AF_NUM)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .done   (done),
        .we     (cmd_q.we),
        .cls    (cls),
        .addr   (cmd_q.addr),
        .wdata  (data_q),
        .rd_val (rd_val),
        .ie_q   (ie_q)
    );

    ireg_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_vld  (done),
        .set_cls  (cls),
        .clr_mask (clr_mask),
        .en       (ie_q),
        .stat_q   (stat_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (done && !cmd_q.we)
            data_q <= rd_val;
        else if (host_we && win == WIN_DATA)
            data_q <= host_wdata;
    end

    always_comb begin
        case (win)
            WIN_CTRL: host_rdata = {{(DATA_W-WE_BIT-1){1'b0}}, cmd_q.we,
                                    {(WE_BIT-ADDR_W){1'b0}}, cmd_q.addr};
            WIN_DATA: host_rdata = data_q;
            WIN_STAT: host_rdata = {{(DATA_W-NCLS-2){1'b0}}, busy, 1'b0, stat_q};
            default:  host_rdata = '0;
        endcase
    end

    p_err_cause_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> ($past(ctrl_wr) && $past(busy)));
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (ie_q == '0) |-> !irq);
    p_read_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_q.we) |=> (data_q == $past(rd_val)));
endmodule

// File: tb/ireg_bridge_test.sv
module ireg_bridge_test;
    localparam int LAT = 4;
    localparam logic [1:0] S_CTRL = 2'd0;
    localparam logic [1:0] S_DATA = 2'd1;
    localparam logic [1:0] S_STAT = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_sel = 2'd0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy;
    logic        irq;
    logic        cmd_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ireg_bridge uut (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .irq        (irq),
        .cmd_err    (cmd_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        host_sel = s; host_we = 1'b1; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        host_sel = s;
        #1;
        d = host_rdata;
    endtask

    task automatic access(input logic [31:0] ctrl);
        wr(S_CTRL, ctrl);
        repeat (LAT) @(negedge clk);
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [31:0] v);
        wr(S_DATA, v);
        access(32'h8000 | 32'(a));
    endtask

    task automatic reg_read(input logic [9:0] a, output logic [31:0] v);
        access(32'(a));
        rd(S_DATA, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(S_CTRL, v); check("R1 ctrl", v, 0);
        rd(S_DATA, v); check("R1 data", v, 0);
        rd(S_STAT, v); check("R1 stat", v, 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 cmd_err", 32'(cmd_err), 0);
        reg_read(10'h3A4, v); check("R1 mask reg", v, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        reg_write(10'h200, 32'hA5A5_0001);
        reg_write(10'h207, 32'h1234_5678);
        rd(S_CTRL, v); check("R3 ctrl readback", v, 32'h0000_8207);
        reg_read(10'h200, v); check("R2 R8 cfg0", v, 32'hA5A5_0001);
        reg_read(10'h207, v); check("R2 R8 cfg7", v, 32'h1234_5678);
        reg_read(10'h203, v); check("R8 cfg3 untouched", v, 0);
        rd(S_STAT, v); check("R9 cfg rd/wr bits", v & 32'h3, 32'h3);
    endtask

    task automatic t_af();
        logic [31:0] v;
        reg_write(10'h381, 32'hCAFE_F00D);
        reg_read(10'h381, v); check("R8 af1", v, 32'hCAFE_F00D);
        reg_read(10'h380, v); check("R8 af0 untouched", v, 0);
        rd(S_STAT, v); check("R9 af rd/wr bits", v & 32'hC, 32'hC);
    endtask

    task automatic t_ie_hold();
        logic [31:0] v;
        reg_write(10'h3A4, 32'hFFFF_FFFF);
        reg_read(10'h3A4, v); check("R6 mask width", v, 32'h7F);
        reg_write(10'h3A4, 32'h0);
        reg_write(10'h3B0, 32'hDEAD_BEEF);
        reg_read(10'h3B0, v); check("R7 hold width", v, 32'h0000_BEEF);
        rd(S_STAT, v); check("R9 mask/hold bits", v & 32'h30, 32'h30);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(S_STAT, 32'h7F);
        reg_write(10'h100, 32'h1111_2222);
        reg_read(10'h100, v); check("R12 unmapped read", v, 0);
        rd(S_STAT, v); check("R12 R9 unmapped class", v, 32'h40);
        reg_read(10'h200, v); check("R12 cfg0 intact", v, 32'hA5A5_0001);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(S_DATA, 32'h55AA_55AA);
        wr(S_CTRL, 32'h0000_0200);
        check("R4 busy after accept", 32'(busy), 1);
        rd(S_STAT, v); check("R4 status busy bit", v & 32'h100, 32'h100);
        wr(S_CTRL, 32'h0000_8201);
        check("R5 cmd_err pulse", 32'(cmd_err), 1);
        check("R4 busy cycle 3", 32'(busy), 1);
        @(negedge clk);
        check("R5 cmd_err one cycle", 32'(cmd_err), 0);
        check("R4 busy cycle 4", 32'(busy), 1);
        @(negedge clk);
        check("R4 busy falls", 32'(busy), 0);
        rd(S_CTRL, v); check("R5 ctrl unchanged", v, 32'h0000_0200);
        rd(S_DATA, v); check("R2 data loaded", v, 32'hA5A5_0001);
        reg_read(10'h201, v); check("R5 cfg1 not written", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(S_STAT, 32'h7F);
        rd(S_STAT, v); check("R10 clear all", v, 0);
        check("R11 irq idle", 32'(irq), 0);
        reg_write(10'h3A4, 32'h2);
        check("R11 masked mask access", 32'(irq), 0);
        reg_read(10'h200, v);
        check("R11 masked cfg read", 32'(irq), 0);
        reg_write(10'h204, 32'h9);
        check("R11 enabled cfg write", 32'(irq), 1);
        wr(S_STAT, 32'h2);
        check("R11 irq after clear", 32'(irq), 0);
        rd(S_STAT, v); check("R10 other bits kept", v, 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cfg();
        t_af();
        t_ie_hold();
        t_unmapped();
        t_busy();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule